// File: doc/BRIEF.md
# Traffic Class Deadline Scheduler

This block picks which of N per-flow queues the packet assembler reads next, and how many octets it reads. The queues live outside the block. Each flow reports four things every cycle: its queue occupancy in octets, its traffic class, the time-stamp of the octet at the head of its queue, and a delay bound. A shared time base arrives as a wrapping 16-bit count. A programmable loop period divides the clock, and the block makes one service decision in each period.

Flows that are bounded in delay, and flows that carry reliable data, normally compete on queue size: the fullest queue is served first. When a delay-bounded flow reaches its service deadline, it overrides that choice. The deadline is the head time-stamp plus the flow's delay bound. Best-effort flows are served only when no delay-bounded or data flow has anything queued. Each grant asks for a full packet payload where the queue holds enough. This keeps overhead per packet low and still meets the deadlines of the time-critical flows.

Top module: `tcd_sched`

## Requirements
- R1: While rst_n is low, grant_vld is 0. After rst_n rises, grant_vld stays 0 until the first loop tick. With a period of P, the first grant is visible on the output after the P-th rising edge.
- R2: A decision is made once every max(P,1) clock cycles. grant_vld is high for at most one cycle per decision, so consecutive grants are exactly max(P,1) cycles apart while some queue stays non-empty. A period of 0 behaves as 1.
- R3: The class of a flow is a 2-bit code: 0 is delay-bounded, 1 is data, 2 is best-effort and 3 is disabled. A disabled flow is never granted, whatever its occupancy.
- R4: If no delay-bounded flow is due, the grant goes to the delay-bounded or data flow with the most octets. Equal occupancies go to the lowest flow index. grant_due is 0 for such a grant.
- R5: A flow's deadline is (head time-stamp + delay bound) mod 2^16. The flow is due when the 16-bit difference (now - deadline), read as signed, is 0 or more. Only a delay-bounded flow with a non-empty queue can be due.
- R6: A due flow is granted in place of the largest-queue choice, and grant_due is 1 for that grant.
- R7: If several flows are due, the one with the largest signed (now - deadline), which is the earliest deadline, wins. Equal values go to the lowest flow index.
- R8: A best-effort flow is granted only when every delay-bounded and data queue is empty. Among best-effort flows the largest wins, and equal occupancies go to the lowest index.
- R9: grant_len equals the smaller of 45 and the granted flow's occupancy. The occupancy is the one sampled in the cycle of the decision.
- R10: If no enabled flow has a non-empty queue at a decision, no grant is issued for that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_period | input | TICK_W | Loop period in clock cycles (0 acts as 1) |
| now_ts | input | TS_W | Current value of the wrapping time base |
| flow_occ | input | N_FLOWS*OCC_W | Queue occupancy in octets, flow i at bits [i*OCC_W +: OCC_W] |
| flow_cls | input | N_FLOWS*2 | Class code per flow, flow i at bits [i*2 +: 2] |
| flow_head_ts | input | N_FLOWS*TS_W | Head-octet time-stamp per flow |
| flow_max_dly | input | N_FLOWS*TS_W | Delay bound per flow (used for class 0) |
| grant_vld | output | 1 | One-cycle grant strobe |
| grant_flow | output | FLOW_W | Index of the granted flow |
| grant_len | output | LEN_W | Octets to read from the granted flow |
| grant_due | output | 1 | Grant was forced by a reached deadline |

## Verification
Deadline override and largest-queue selection can fall in the same decision. This happens when a small delay-bounded queue becomes due while a much larger data queue is waiting. The bench provokes it both in directed cases and across thousands of mixed-class random patterns, where lateness straddles zero and the time base wraps. Each grant is judged against an arithmetic model that applies the precedence rules in order: the due flow must win, with grant_due set and the short length. Several due flows with equal or different lateness test the earliest-deadline tie-break in the same way.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

    typedef enum logic [1:0] {
        CLS_BOUNDED = 2'd0,
        CLS_DATA    = 2'd1,
        CLS_BEST    = 2'd2,
        CLS_OFF     = 2'd3
    } tcd_cls_e;

    localparam int unsigned PAYLOAD_MAX = 45;
    localparam int unsigned LEN_W       = 6;

endpackage

// File: rtl/tcd_tick_gen.sv
module tcd_tick_gen #(
    parameter int unsigned TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] period,
    output logic              tick
);

    typedef struct packed {
        logic [TICK_W-1:0] cnt;
    } tick_st_t;

    tick_st_t          st_d, st_q;
    logic [TICK_W-1:0] last_cnt;

    always_comb begin
        last_cnt = (period == '0) ? '0 : period - 1'b1;
        tick     = (st_q.cnt >= last_cnt);
        st_d     = st_q;
        if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tcd_slack_eval.sv
module tcd_slack_eval #(
    parameter int unsigned TS_W = 16
) (
    input  logic [TS_W-1:0] head_ts,
    input  logic [TS_W-1:0] max_dly,
    input  logic [TS_W-1:0] now_ts,
    output logic [TS_W-1:0] lateness,
    output logic            reached
);

    logic [TS_W-1:0] deadline;

    always_comb begin
        deadline = head_ts + max_dly;
        lateness = now_ts - deadline;
        reached  = ~lateness[TS_W-1];
    end

endmodule

// File: rtl/tcd_pick.sv
module tcd_pick
    import tcd_pkg::*;
#(
    parameter int unsigned N_FLOWS = 4,
    parameter int unsigned OCC_W   = 10,
    parameter int unsigned TS_W    = 16,
    parameter int unsigned FLOW_W  = 2
) (
    input  logic [N_FLOWS*OCC_W-1:0] flow_occ,
    input  logic [N_FLOWS*2-1:0]     flow_cls,
    input  logic [N_FLOWS*TS_W-1:0]  flow_late,
    input  logic [N_FLOWS-1:0]       flow_reached,
    output logic                     pick_vld,
    output logic [FLOW_W-1:0]        pick_idx,
    output logic                     pick_due,
    output logic [OCC_W-1:0]         pick_occ
);

    logic              hi_found, due_found, lo_found;
    logic [FLOW_W-1:0] hi_idx, due_idx, lo_idx;
    logic [OCC_W-1:0]  hi_occ, due_occ, lo_occ;
    logic [TS_W-1:0]   due_late;
    logic [OCC_W-1:0]  occ_i;
    logic [1:0]        cls_i;
    logic [TS_W-1:0]   late_i;

    always_comb begin
        hi_found  = 1'b0;
        due_found = 1'b0;
        lo_found  = 1'b0;
        hi_idx    = '0;
        due_idx   = '0;
        lo_idx    = '0;
        hi_occ    = '0;
        due_occ   = '0;
        lo_occ    = '0;
        due_late  = '0;
        occ_i     = '0;
        cls_i     = '0;
        late_i    = '0;
        for (int i = 0; i < N_FLOWS; i++) begin
            occ_i  = flow_occ[i*OCC_W +: OCC_W];
            cls_i  = flow_cls[i*2 +: 2];
            late_i = flow_late[i*TS_W +: TS_W];
            if (occ_i != '0) begin
                if (cls_i == CLS_BOUNDED || cls_i == CLS_DATA) begin
                    if (!hi_found || occ_i > hi_occ) begin
                        hi_found = 1'b1;
                        hi_idx   = FLOW_W'(i);
                        hi_occ   = occ_i;
                    end
                end
                if (cls_i == CLS_BOUNDED && flow_reached[i]) begin
                    if (!due_found || $signed(late_i) > $signed(due_late)) begin
                        due_found = 1'b1;
                        due_idx   = FLOW_W'(i);
                        due_occ   = occ_i;
                        due_late  = late_i;
                    end
                end
                if (cls_i == CLS_BEST) begin
                    if (!lo_found || occ_i > lo_occ) begin
                        lo_found = 1'b1;
                        lo_idx   = FLOW_W'(i);
                        lo_occ   = occ_i;
                    end
                end
            end
        end

        pick_vld = 1'b0;
        pick_idx = '0;
        pick_due = 1'b0;
        pick_occ = '0;
        if (due_found) begin
            pick_vld = 1'b1;
            pick_idx = due_idx;
            pick_due = 1'b1;
            pick_occ = due_occ;
        end else if (hi_found) begin
            pick_vld = 1'b1;
            pick_idx = hi_idx;
            pick_occ = hi_occ;
        end else if (lo_found) begin
            pick_vld = 1'b1;
            pick_idx = lo_idx;
            pick_occ = lo_occ;
        end
    end

endmodule

// File: rtl/tcd_sched.sv
module tcd_sched
    import tcd_pkg::*;
#(
    parameter int unsigned N_FLOWS = 4,
    parameter int unsigned OCC_W   = 10,
    parameter int unsigned TS_W    = 16,
    parameter int unsigned TICK_W  = 16,
    localparam int unsigned FLOW_W = (N_FLOWS > 1) ? $clog2(N_FLOWS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TICK_W-1:0]        tick_period,
    input  logic [TS_W-1:0]          now_ts,
    input  logic [N_FLOWS*OCC_W-1:0] flow_occ,
    input  logic [N_FLOWS*2-1:0]     flow_cls,
    input  logic [N_FLOWS*TS_W-1:0]  flow_head_ts,
    input  logic [N_FLOWS*TS_W-1:0]  flow_max_dly,
    output logic                     grant_vld,
    output logic [FLOW_W-1:0]        grant_flow,
    output logic [LEN_W-1:0]         grant_len,
    output logic                     grant_due
);

    typedef struct packed {
        logic              vld;
        logic [FLOW_W-1:0] flow;
        logic [LEN_W-1:0]  len;
        logic              due;
    } grant_st_t;

    grant_st_t               st_d, st_q;
    logic                    tick;
    logic [N_FLOWS*TS_W-1:0] late_vec;
    logic [N_FLOWS-1:0]      reached_vec;
    logic                    pick_vld;
    logic [FLOW_W-1:0]       pick_idx;
    logic                    pick_due;
    logic [OCC_W-1:0]        pick_occ;

    tcd_tick_gen #(
        .TICK_W (TICK_W)
    ) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (tick_period),
        .tick   (tick)
    );

    for (genvar g = 0; g < N_FLOWS; g++) begin : g_slack
        tcd_slack_eval #(
            .TS_W (TS_W)
        ) slack_i (
            .head_ts  (flow_head_ts[g*TS_W +: TS_W]),
            .max_dly  (flow_max_dly[g*TS_W +: TS_W]),
            .now_ts   (now_ts),
            .lateness (late_vec[g*TS_W +: TS_W]),
            .reached  (reached_vec[g])
        );
    end

    tcd_pick #(
        .N_FLOWS (N_FLOWS),
        .OCC_W   (OCC_W),
        .TS_W    (TS_W),
        .FLOW_W  (FLOW_W)
    ) pick_i (
        .flow_occ     (flow_occ),
        .flow_cls     (flow_cls),
        .flow_late    (late_vec),
        .flow_reached (reached_vec),
        .pick_vld     (pick_vld),
        .pick_idx     (pick_idx),
        .pick_due     (pick_due),
        .pick_occ     (pick_occ)
    );

    always_comb begin
        st_d = '0;
        if (tick && pick_vld) begin
            st_d.vld  = 1'b1;
            st_d.flow = pick_idx;
            st_d.due  = pick_due;
            if (pick_occ > OCC_W'(PAYLOAD_MAX)) begin
                st_d.len = LEN_W'(PAYLOAD_MAX);
            end else begin
                st_d.len = LEN_W'(pick_occ);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_vld  = st_q.vld;
    assign grant_flow = st_q.flow;
    assign grant_len  = st_q.len;
    assign grant_due  = st_q.due;

endmodule

// File: rtl/tcd_sched_chk.sv
module tcd_sched_chk
    import tcd_pkg::*;
#(
    parameter int unsigned N_FLOWS = 4,
    parameter int unsigned OCC_W   = 10,
    parameter int unsigned FLOW_W  = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_FLOWS*OCC_W-1:0] flow_occ,
    input logic [N_FLOWS*2-1:0]     flow_cls,
    input logic                     grant_vld,
    input logic [FLOW_W-1:0]        grant_flow,
    input logic [LEN_W-1:0]         grant_len,
    input logic                     grant_due
);

    logic [N_FLOWS*OCC_W-1:0] prev_occ;
    logic [N_FLOWS*2-1:0]     prev_cls;
    logic                     prev_hi_busy, prev_any_busy;
    logic                     hi_busy, any_busy;
    logic [OCC_W-1:0]         prev_occ_sel;
    logic [1:0]               prev_cls_sel;
    logic [OCC_W-1:0]         exp_len;

    always_comb begin
        hi_busy  = 1'b0;
        any_busy = 1'b0;
        for (int i = 0; i < N_FLOWS; i++) begin
            if (flow_occ[i*OCC_W +: OCC_W] != '0) begin
                if (flow_cls[i*2 +: 2] == CLS_BOUNDED || flow_cls[i*2 +: 2] == CLS_DATA) begin
                    hi_busy = 1'b1;
                end
                if (flow_cls[i*2 +: 2] != CLS_OFF) begin
                    any_busy = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_occ      <= '0;
            prev_cls      <= '0;
            prev_hi_busy  <= 1'b0;
            prev_any_busy <= 1'b0;
        end else begin
            prev_occ      <= flow_occ;
            prev_cls      <= flow_cls;
            prev_hi_busy  <= hi_busy;
            prev_any_busy <= any_busy;
        end
    end

    assign prev_occ_sel = prev_occ[grant_flow*OCC_W +: OCC_W];
    assign prev_cls_sel = prev_cls[grant_flow*2 +: 2];
    assign exp_len      = (prev_occ_sel > OCC_W'(PAYLOAD_MAX)) ? OCC_W'(PAYLOAD_MAX) : prev_occ_sel;

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !grant_vld); // R1
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> (grant_len >= LEN_W'(1) && grant_len <= LEN_W'(PAYLOAD_MAX))); // R9
    AST_LEN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> (OCC_W'(grant_len) == exp_len)); // R9
    AST_OFF_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> (prev_cls_sel != CLS_OFF)); // R3
    AST_DUE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && grant_due) |-> (prev_cls_sel == CLS_BOUNDED)); // R6
    AST_BEST_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && prev_cls_sel == CLS_BEST) |-> !prev_hi_busy); // R8
    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !prev_any_busy |-> !grant_vld); // R10

endmodule

bind tcd_sched tcd_sched_chk #(
    .N_FLOWS (N_FLOWS),
    .OCC_W   (OCC_W),
    .FLOW_W  (FLOW_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .flow_occ   (flow_occ),
    .flow_cls   (flow_cls),
    .grant_vld  (grant_vld),
    .grant_flow (grant_flow),
    .grant_len  (grant_len),
    .grant_due  (grant_due)
);

// File: tb/tcd_sched_tb_top.sv
module tcd_sched_tb_top;

    localparam int NF = 4;
    localparam int OW = 10;
    localparam int TW = 16;
    localparam int KW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [KW-1:0]   tick_period = 16'd1;
    logic [TW-1:0]   now_ts = '0;
    logic [NF*OW-1:0] flow_occ;
    logic [NF*2-1:0]  flow_cls;
    logic [NF*TW-1:0] flow_head_ts;
    logic [NF*TW-1:0] flow_max_dly;
    logic            grant_vld;
    logic [1:0]      grant_flow;
    logic [5:0]      grant_len;
    logic            grant_due;

    logic [OW-1:0] occ_a [NF];
    logic [1:0]    cls_a [NF];
    logic [TW-1:0] head_a [NF];
    logic [TW-1:0] mx_a [NF];

    int total = 0;
    int bad = 0;
    logic [31:0] rng = 32'h1bad_c0de;

    logic       e_vld;
    logic [1:0] e_flow;
    logic [5:0] e_len;
    logic       e_due;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NF; i++) begin
            flow_occ[i*OW +: OW]     = occ_a[i];
            flow_cls[i*2 +: 2]       = cls_a[i];
            flow_head_ts[i*TW +: TW] = head_a[i];
            flow_max_dly[i*TW +: TW] = mx_a[i];
        end
    end

    tcd_sched #(.N_FLOWS(NF), .OCC_W(OW), .TS_W(TW), .TICK_W(KW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_period(tick_period), .now_ts(now_ts),
        .flow_occ(flow_occ), .flow_cls(flow_cls), .flow_head_ts(flow_head_ts),
        .flow_max_dly(flow_max_dly), .grant_vld(grant_vld), .grant_flow(grant_flow),
        .grant_len(grant_len), .grant_due(grant_due)
    );

    initial begin
        #1500000;
        total++;
        bad++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13;
        x ^= x >> 17;
        x ^= x << 5;
        return x;
    endfunction

    task automatic clear_flows();
        for (int i = 0; i < NF; i++) begin
            occ_a[i] = '0; cls_a[i] = 2'd3; head_a[i] = '0; mx_a[i] = '0;
        end
    endtask

    task automatic set_flow(input int i, input logic [1:0] c, input int o,
                            input logic [TW-1:0] h, input logic [TW-1:0] m);
        cls_a[i] = c; occ_a[i] = OW'(o); head_a[i] = h; mx_a[i] = m;
    endtask

    // Model of the precedence rules, written from R3..R10.
    task automatic model();
        int best_hi = -1, best_due = -1, best_lo = -1;
        int late_best = 0;
        int sel = -1;
        e_vld = 0; e_flow = 0; e_len = 0; e_due = 0;
        for (int i = 0; i < NF; i++) begin
            int o = int'(occ_a[i]);
            logic [TW-1:0] dl = head_a[i] + mx_a[i];
            int late = int'($signed(now_ts - dl));
            if (o == 0) continue;
            if (cls_a[i] <= 2'd1 && (best_hi < 0 || o > int'(occ_a[best_hi]))) best_hi = i;
            if (cls_a[i] == 2'd0 && late >= 0 && (best_due < 0 || late > late_best)) begin
                best_due = i; late_best = late;
            end
            if (cls_a[i] == 2'd2 && (best_lo < 0 || o > int'(occ_a[best_lo]))) best_lo = i;
        end
        if (best_due >= 0) begin sel = best_due; e_due = 1; end
        else if (best_hi >= 0) sel = best_hi;
        else sel = best_lo;
        if (sel >= 0) begin
            e_vld  = 1;
            e_flow = 2'(sel);
            e_len  = (occ_a[sel] > 45) ? 6'd45 : 6'(occ_a[sel]);
        end
    endtask

    task automatic check(input string tag);
        total++;
        if (grant_vld !== e_vld ||
            (e_vld && (grant_flow !== e_flow || grant_len !== e_len || grant_due !== e_due))) begin
            bad++;
            $display("FAIL %s: actual vld=%0b flow=%0d len=%0d due=%0b expected vld=%0b flow=%0d len=%0d due=%0b",
                     tag, grant_vld, grant_flow, grant_len, grant_due, e_vld, e_flow, e_len, e_due);
        end
    endtask

    // Inputs are set at a falling edge; the grant appears after the next rising edge (period 1).
    task automatic run_case(input string tag);
        model();
        @(negedge clk);
        check(tag);
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic wait_pulse();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!grant_vld && n < 100);
    endtask

    task automatic gap_check(input int p, input string tag);
        int gap = 0;
        int exp_gap = (p == 0) ? 1 : p;
        tick_period = KW'(p);
        wait_pulse();
        wait_pulse();
        do begin
            @(negedge clk);
            gap++;
        end while (!grant_vld && gap < 100);
        total++;
        if (gap != exp_gap) begin
            bad++;
            $display("FAIL %s: actual gap=%0d expected gap=%0d", tag, gap, exp_gap);
        end
    endtask

    initial begin
        clear_flows();
        set_flow(0, 2'd1, 10, 16'h0, 16'h0);
        tick_period = 16'd6;
        repeat (3) @(negedge clk);
        check_bit("R1 reset holds grant low", grant_vld, 1'b0);
        rst_n = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            check_bit("R1 no grant before first tick", grant_vld, 1'b0);
        end
        @(negedge clk);
        check_bit("R1 first grant after P edges", grant_vld, 1'b1);

        gap_check(4, "R2 period 4");
        gap_check(7, "R2 period 7");
        gap_check(0, "R2 period 0 acts as 1");
        gap_check(1, "R2 period 1");

        tick_period = 16'd1;
        @(negedge clk);
        now_ts = 16'h1000;

        clear_flows();
        for (int i = 0; i < NF; i++) set_flow(i, 2'd1, 20, 16'h1000, 16'h0);
        run_case("R4 equal occupancy lowest index");

        clear_flows();
        set_flow(0, 2'd0, 5, 16'h1000, 16'h0100);
        set_flow(1, 2'd0, 30, 16'h1000, 16'h0100);
        set_flow(2, 2'd1, 30, 16'h1000, 16'h0);
        set_flow(3, 2'd0, 7, 16'h1000, 16'h0100);
        run_case("R4 largest not-due queue");

        clear_flows();
        set_flow(0, 2'd1, 500, 16'h0, 16'h0);
        set_flow(3, 2'd0, 3, 16'h0F00, 16'h0100);
        run_case("R6 deadline overrides larger data queue");

        clear_flows();
        set_flow(1, 2'd0, 9, 16'h0F00, 16'h0080);
        set_flow(2, 2'd0, 4, 16'h0F00, 16'h0040);
        run_case("R7 earliest deadline wins");
        set_flow(2, 2'd0, 4, 16'h0F00, 16'h0080);
        run_case("R7 equal deadline lowest index");

        clear_flows();
        now_ts = 16'h000F;
        set_flow(0, 2'd0, 2, 16'hFFF0, 16'h0020);
        set_flow(1, 2'd1, 300, 16'h0, 16'h0);
        run_case("R5 wrap one before deadline");
        now_ts = 16'h0010;
        run_case("R5 wrap exactly at deadline");

        clear_flows();
        set_flow(0, 2'd0, 0, 16'h0, 16'h0001);
        set_flow(1, 2'd1, 10, 16'h0, 16'h0);
        run_case("R5 empty overdue flow not due");

        clear_flows();
        set_flow(0, 2'd2, 200, 16'h0, 16'h0);
        set_flow(2, 2'd2, 300, 16'h0, 16'h0);
        set_flow(3, 2'd1, 1, 16'h0, 16'h0);
        run_case("R8 best-effort waits for data");
        occ_a[3] = '0;
        run_case("R8 largest best-effort when others empty");
        occ_a[0] = 10'd300;
        run_case("R8 best-effort tie lowest index");

        clear_flows();
        set_flow(1, 2'd3, 900, 16'h0, 16'h0);
        run_case("R3 disabled flow never granted");
        set_flow(2, 2'd2, 3, 16'h0, 16'h0);
        run_case("R3 disabled flow skipped");

        clear_flows();
        for (int i = 0; i < NF; i++) cls_a[i] = 2'(i % 3);
        run_case("R10 all empty no grant");

        clear_flows();
        set_flow(0, 2'd1, 45, 16'h0, 16'h0);
        run_case("R9 occupancy 45");
        occ_a[0] = 10'd46;
        run_case("R9 occupancy 46 capped");
        occ_a[0] = 10'd1;
        run_case("R9 occupancy 1");

        for (int it = 0; it < 4000; it++) begin
            rng = nxt(rng);
            now_ts = rng[15:0];
            for (int i = 0; i < NF; i++) begin
                rng = nxt(rng);
                cls_a[i] = rng[1:0];
                case (rng[3:2])
                    2'd0: occ_a[i] = '0;
                    2'd1: occ_a[i] = OW'(1 + rng[6:4]);
                    2'd2: occ_a[i] = OW'(40 + rng[7:4]);
                    default: occ_a[i] = rng[17:8];
                endcase
                head_a[i] = now_ts - TW'(rng[23:18]);
                mx_a[i]   = TW'(rng[29:24]);
            end
            run_case("R6 R7 R4 R8 random mix");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule